// File: doc/BRIEF.md
# Instruction Prefetch Queue with Two-Position Opcode Lookahead

This block buffers instruction bytes ahead of the decoder. It asks the memory bus for aligned 16-bit words while the queue has room, and it stores the bytes in a small circular buffer. It presents one instruction at a time to the decode stage. An instruction is a single opcode byte. When the top bit of the opcode is set, the opcode is followed by a two-byte little-endian immediate, so every instruction is 1 or 3 bytes long.

Two opcode decoders look at the buffer at the same time. One decoder reads the byte at the read pointer. The other reads the byte three positions further on. An instruction without an immediate is popped as soon as it is taken. An instruction with an immediate leaves its three bytes in the buffer while the operand path uses them. The next opcode therefore sits either at the read pointer or three bytes past it. A single registered flag from the previous issue selects between the two decoder results, so the selection needs no serial length calculation.

A redirect of the instruction pointer empties the buffer and restarts fetching at the word that holds the target. When the target address is odd, the low byte of the first returned word is discarded, so the first stored byte is the target opcode.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is empty, `dec_ready_o` is 0, `fetch_req_o` is 1 and `fetch_addr_o` equals the reset address (0 by default).
- R2: A word is accepted only in a cycle where `fetch_req_o` and `fill_valid_i` are both 1. `fetch_req_o` is 1 only while at least two byte slots are free, and it is 0 during a flush. Each accepted word advances `fetch_addr_o` by 2, and a word offered while `fetch_req_o` is 0 is dropped.
- R3: Bit 7 of an opcode set to 1 means the opcode carries a 16-bit immediate (length 3). Bit 7 set to 0 means length 1. `dec_has_imm_o` reports this bit for the presented opcode.
- R4: `dec_ready_o` is 1 only when every byte of the presented instruction is in the queue. When it is 0, the instruction is not issued.
- R5: After an issued instruction without an immediate, the next presented opcode is the byte at the read pointer (offset 0). After an issued instruction with an immediate, the next presented opcode is the byte three positions past the read pointer.
- R6: `dec_imm_o` holds the immediate with the byte that directly follows the opcode in bits 7:0 and the following byte in bits 15:8. Within a fetched word, bits 7:0 are the byte at the lower (even) address.
- R7: A flush empties the queue and clears the pending-immediate state. It sets `fetch_addr_o` to the target with bit 0 cleared. For an odd target, only bits 15:8 of the first accepted word are stored.
- R8: A word offered in the same cycle as a flush is not stored.
- R9: Asserting `dec_take_i` while `dec_ready_o` is 0 changes nothing: the queue contents and the next presented instruction stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronous to clk |
| flush_i | input | 1 | Redirect: discard queued bytes and refetch from flush_addr_i |
| flush_addr_i | input | 16 | Byte address of the redirect target |
| fetch_req_o | output | 1 | Queue can take a word this cycle |
| fetch_addr_o | output | 16 | Even byte address of the word wanted next |
| fill_valid_i | input | 1 | Bus returns the word at fetch_addr_o this cycle |
| fill_data_i | input | 16 | Returned word, lower address in bits 7:0 |
| dec_ready_o | output | 1 | Presented instruction is complete in the queue |
| dec_opcode_o | output | 8 | Presented opcode |
| dec_has_imm_o | output | 1 | Presented opcode carries a 16-bit immediate |
| dec_imm_o | output | 16 | Immediate of the presented instruction |
| dec_take_i | input | 1 | Decoder issues the presented instruction |

## Verification
Every decode output is combinational from registered queue state. A word, take or flush applied in one cycle therefore shows its effect on `dec_*` and `fetch_*` in the cycle that follows the next rising edge, while `fetch_req_o` also follows `flush_i` within the same cycle. The bench drives each input on the falling edge and reads the outputs one nanosecond later. So every check sees the state committed at the previous rising edge, together with the inputs of the current cycle. The test sequences are built so that the offset-3 lookahead, the partial-instruction wait and the odd-target realignment each produce a different opcode or ready value than a wrong choice would.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int OPC_W     = 8;
  localparam int SHORT_LEN = 1;
  localparam int LONG_LEN  = 3;
  localparam int LEAD_OFF  = 3;                       // second decoder position
  localparam int WIN       = LEAD_OFF + LONG_LEN;     // bytes visible to decode

  function automatic logic opc_is_long(input logic [OPC_W-1:0] opc);
    return opc[OPC_W-1];
  endfunction
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 8,
  parameter int WIN   = 6,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic [1:0]           push_n_i,   // 0, 1 (high byte only) or 2
  input  logic [15:0]          push_data_i,
  input  logic [2:0]           pop_n_i,
  output logic [CW-1:0]        count_o,
  output logic [WIN-1:0][7:0]  win_o
);
  logic [DEPTH-1:0][7:0] mem_q, mem_d;
  logic [PW-1:0]         rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  upd_en;

  always_comb begin
    mem_d = mem_q;
    if (push_n_i == 2'd2) begin
      mem_d[wr_q]            = push_data_i[7:0];
      mem_d[wr_q + PW'(1)]   = push_data_i[15:8];
    end else if (push_n_i == 2'd1) begin
      mem_d[wr_q]            = push_data_i[15:8];
    end
  end

  always_comb begin
    if (clear_i) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      rd_d  = rd_q + PW'(pop_n_i);
      wr_d  = wr_q + PW'(push_n_i);
      cnt_d = cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign upd_en = clear_i || (push_n_i != 2'd0) || (pop_n_i != 3'd0);

  always_ff @(posedge clk) begin
    if (!clear_i && push_n_i != 2'd0) mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < WIN; gi++) begin : g_win
      assign win_o[gi] = mem_q[rd_q + PW'(gi)];
    end
  endgenerate

  assign count_o = cnt_q;

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= DEPTH);
  assert_pop_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |-> int'(pop_n_i) <= int'(cnt_q));
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
  parameter int          AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  input  logic          accept_i,
  output logic [AW-1:0] addr_o,
  output logic          skip_lo_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          skip_q, skip_d;
  logic          en;

  always_comb begin
    addr_d = addr_q;
    skip_d = skip_q;
    if (flush_i) begin
      addr_d = {flush_addr_i[AW-1:1], 1'b0};
      skip_d = flush_addr_i[0];
    end else if (accept_i) begin
      addr_d = addr_q + AW'(2);
      skip_d = 1'b0;
    end
  end

  assign en = flush_i || accept_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= {RESET_ADDR[AW-1:1], 1'b0};
      skip_q <= RESET_ADDR[0];
    end else if (en) begin
      addr_q <= addr_d;
      skip_q <= skip_d;
    end
  end

  assign addr_o    = addr_q;
  assign skip_lo_o = skip_q;

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && !flush_i) |=> addr_o == $past(addr_o) + AW'(2));
  assert_flush_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (addr_o[AW-1:1] == $past(flush_addr_i[AW-1:1])) && !addr_o[0]);
endmodule

// File: rtl/pfq_decode.sv
module pfq_decode
  import pfq_pkg::*;
#(
  parameter int OFF = 0,
  parameter int CW  = 4
) (
  input  logic [OPC_W-1:0] opc_i,
  input  logic [7:0]       b1_i,
  input  logic [7:0]       b2_i,
  input  logic [CW-1:0]    count_i,
  output logic             ready_o,
  output logic             long_o,
  output logic [15:0]      imm_o
);
  int need;

  always_comb begin
    long_o  = opc_is_long(opc_i);
    need    = OFF + (long_o ? LONG_LEN : SHORT_LEN);
    ready_o = int'(count_i) >= need;
    imm_o   = {b2_i, b1_i};
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int            DEPTH      = 8,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] RESET_ADDR = '0,
  localparam int           CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [AW-1:0] flush_addr_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fill_valid_i,
  input  logic [15:0]   fill_data_i,
  output logic          dec_ready_o,
  output logic [7:0]    dec_opcode_o,
  output logic          dec_has_imm_o,
  output logic [15:0]   dec_imm_o,
  input  logic          dec_take_i
);
  localparam int NDEC = 2;

  logic [CW-1:0]        count;
  logic [WIN-1:0][7:0]  win;
  logic                 skip_lo;
  logic                 fill_acc;
  logic [1:0]           push_n;
  logic [2:0]           pop_n;
  logic                 take_ok;
  logic                 prev_long_q, prev_long_d;

  logic [NDEC-1:0]        d_rdy, d_long;
  logic [NDEC-1:0][15:0]  d_imm;
  logic [NDEC-1:0][7:0]   d_opc;

  // word accepted only with two free slots and no redirect
  assign fetch_req_o = (int'(count) <= DEPTH - 2) && !flush_i;
  assign fill_acc    = fill_valid_i && fetch_req_o;
  assign push_n      = !fill_acc ? 2'd0 : (skip_lo ? 2'd1 : 2'd2);

  pfq_fetch #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .accept_i     (fill_acc),
    .addr_o       (fetch_addr_o),
    .skip_lo_o    (skip_lo)
  );

  pfq_store #(.DEPTH(DEPTH), .WIN(WIN)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (flush_i),
    .push_n_i    (push_n),
    .push_data_i (fill_data_i),
    .pop_n_i     (pop_n),
    .count_o     (count),
    .win_o       (win)
  );

  genvar gd;
  generate
    for (gd = 0; gd < NDEC; gd++) begin : g_dec
      localparam int OFF = gd * LEAD_OFF;
      assign d_opc[gd] = win[OFF];
      pfq_decode #(.OFF(OFF), .CW(CW)) u_dec (
        .opc_i   (win[OFF]),
        .b1_i    (win[OFF+1]),
        .b2_i    (win[OFF+2]),
        .count_i (count),
        .ready_o (d_rdy[gd]),
        .long_o  (d_long[gd]),
        .imm_o   (d_imm[gd])
      );
    end
  endgenerate

  // previous issue's operand flag picks the decoder
  always_comb begin
    dec_ready_o   = d_rdy[prev_long_q];
    dec_opcode_o  = d_opc[prev_long_q];
    dec_has_imm_o = d_long[prev_long_q];
    dec_imm_o     = d_imm[prev_long_q];
  end

  assign take_ok = dec_take_i && dec_ready_o && !flush_i;

  always_comb begin
    pop_n       = 3'd0;
    prev_long_d = prev_long_q;
    if (flush_i) begin
      prev_long_d = 1'b0;
    end else if (take_ok) begin
      pop_n       = (prev_long_q ? 3'(LEAD_OFF) : 3'd0) + (dec_has_imm_o ? 3'd0 : 3'd1);
      prev_long_d = dec_has_imm_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  prev_long_q <= 1'b0;
    else if (flush_i || take_ok) prev_long_q <= prev_long_d;
  end

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (count == '0) && !dec_ready_o);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_ready_o && !fill_acc && !flush_i) |=> $stable(count) && $stable(prev_long_q));
  assert_short_pops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ok && !dec_has_imm_o && !prev_long_q && !fill_acc) |=> count == $past(count) - CW'(1));
endmodule

// File: tb/pfq_top_tb.sv
module pfq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i;
  logic [15:0] flush_addr_i;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic        fill_valid_i;
  logic [15:0] fill_data_i;
  logic        dec_ready_o;
  logic [7:0]  dec_opcode_o;
  logic        dec_has_imm_o;
  logic [15:0] dec_imm_o;
  logic        dec_take_i;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  pfq_top u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i),
    .dec_ready_o(dec_ready_o), .dec_opcode_o(dec_opcode_o),
    .dec_has_imm_o(dec_has_imm_o), .dec_imm_o(dec_imm_o), .dec_take_i(dec_take_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs on the falling edge; outputs read 1 ns later
  task automatic drive(input logic fv, input logic [15:0] fd, input logic tk,
                       input logic fl, input logic [15:0] fa);
    @(negedge clk);
    fill_valid_i = fv; fill_data_i = fd; dec_take_i = tk;
    flush_i = fl; flush_addr_i = fa;
    #1;
  endtask

  task automatic idle();         drive(1'b0, 16'h0, 1'b0, 1'b0, 16'h0); endtask
  task automatic fill(input logic [15:0] w); drive(1'b1, w, 1'b0, 1'b0, 16'h0); endtask
  task automatic take();         drive(1'b0, 16'h0, 1'b1, 1'b0, 16'h0); endtask

  task automatic t_reset();
    rst_n = 1'b0;
    fill_valid_i = 1'b0; fill_data_i = '0; dec_take_i = 1'b0;
    flush_i = 1'b0; flush_addr_i = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    idle();
    check("R1 ready", dec_ready_o, 0);
    check("R1 req", fetch_req_o, 1);
    check("R1 addr", fetch_addr_o, 16'h0000);
  endtask

  // program: 05 | 85 1234 | 86 BEEF | 07
  task automatic t_stream();
    fill(16'h8505);
    take();
    check("R2 addr step", fetch_addr_o, 16'h0002);
    check("R3 short ready", dec_ready_o, 1);
    check("R3 short opcode", dec_opcode_o, 8'h05);
    check("R3 short flag", dec_has_imm_o, 0);
    take();
    check("R4 partial long", dec_ready_o, 0);
    fill(16'h1234);
    check("R9 take ignored", dec_ready_o, 0);
    take();
    check("R9 opcode kept", dec_opcode_o, 8'h85);
    check("R4 long ready", dec_ready_o, 1);
    check("R3 long flag", dec_has_imm_o, 1);
    check("R6 imm order", dec_imm_o, 16'h1234);
    fill(16'hEF86);
    check("R4 offset3 empty", dec_ready_o, 0);
    fill(16'h07BE);
    check("R4 offset3 partial", dec_ready_o, 0);
    fill(16'hFFFF);
    check("R2 req when full", fetch_req_o, 0);
    check("R5 offset3 ready", dec_ready_o, 1);
    check("R5 offset3 opcode", dec_opcode_o, 8'h86);
    check("R6 imm split words", dec_imm_o, 16'hBEEF);
    take();
    check("R2 dropped fill addr", fetch_addr_o, 16'h0008);
    take();
    check("R5 after long", dec_opcode_o, 8'h07);
    check("R5 after long ready", dec_ready_o, 1);
    check("R3 after long flag", dec_has_imm_o, 0);
    idle();
    check("R2 drained ready", dec_ready_o, 0);
    check("R2 drained req", fetch_req_o, 1);
  endtask

  task automatic t_flush();
    fill(16'h3480);
    fill(16'h0012);
    take();
    check("R6 setup", dec_imm_o, 16'h1234);
    drive(1'b1, 16'h0404, 1'b0, 1'b1, 16'h0021);
    check("R8 req during flush", fetch_req_o, 0);
    idle();
    check("R8 fill dropped", dec_ready_o, 0);
    check("R7 aligned addr", fetch_addr_o, 16'h0020);
    check("R7 req after", fetch_req_o, 1);
    fill(16'h0399);
    idle();
    check("R7 odd target opcode", dec_opcode_o, 8'h03);
    check("R7 state cleared", dec_ready_o, 1);
    check("R7 addr step", fetch_addr_o, 16'h0022);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_flush();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule